// File: doc/BRIEF.md
# Manual Serial Pin Sequencer

This block lets software drive a serial link to a power-management device one step at a time. Software writes a 16-bit command word, and the block carries out one primitive. A primitive either sets the chip-select level, gives one clock pulse, or shifts a byte out over one, two or four data lanes. It is used during bring-up, for example to reset the slave, before the automatic transfer engine owns the link. A multiplexer passes either the sequencer's pin levels or the automatic engine's pin levels to the link. Software polls an idle flag to learn when everything it queued has finished.

The sequencer is a three-state machine.
- IDLE holds the pins steady and takes the pending command. A chip-select command is applied right there. A clocked command moves the machine to LOW.
- LOW holds the clock low for `HALF_CYC` cycles and then goes to HIGH.
- HIGH holds the clock high for `HALF_CYC` cycles. It then goes back to LOW with the next lane bits, or to IDLE after the last clock.

A one-entry buffer in front of the machine holds one further command while a primitive runs.

Top module: `manual_link_seq`

## Requirements
- R1: After reset, chip select is high, the clock is low, all four data lanes are 0 and `sync_idle` is 1.
- R2: A command is taken only if all of these hold: `man_en` is 1, bit 13 (the write flag) is 1, and bits 11:8 hold one of the codes 0, 1, 2, 8, 9 or 10. Any other command leaves the pins and `sync_idle` unchanged.
- R3: Code 0 drives chip select high and code 1 drives it low. The level appears one cycle after the IDLE state takes the command, and no clock pulse is produced.
- R4: Code 2 produces one clock pulse: `HALF_CYC` cycles low, then `HALF_CYC` cycles high, with the lanes unchanged.
- R5: Code 8 shifts bits 7:0 MSB first on lane 0 over 8 clock pulses. Lanes change only while the clock is low, and lanes 3:1 are 0.
- R6: Code 9 shifts the byte over 4 pulses. Each pulse puts two bits on lanes 1:0, with the higher bit on lane 1.
- R7: Code 10 shifts the byte over 2 pulses. Each pulse puts four bits on lanes 3:0, with the higher bit on lane 3.
- R8: A command taken while a primitive runs waits in a one-entry buffer and runs next. A command that arrives while that buffer is full is dropped.
- R9: `sync_idle` goes low in the cycle after a command is taken. It stays low until the buffer is empty and the machine is back in IDLE.
- R10: The link pins carry the sequencer's levels only while both `man_en` and `man_sel` are 1. Otherwise they carry the automatic engine's pins in the same cycle.
- R11: The slave reset series runs to completion when issued with idle polling: chip-select low, one single-lane byte, chip-select high, then four single-lane bytes. It produces 40 clock pulses and leaves chip select high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_wr | input | 1 | Command write strobe |
| cmd_data | input | 16 | Command word: bit 13 write flag, 11:8 opcode, 7:0 byte |
| man_en | input | 1 | Manual path enable |
| man_sel | input | 1 | Pin source select, 1 = manual |
| auto_cs_n | input | 1 | Chip select from the automatic engine |
| auto_sck | input | 1 | Clock from the automatic engine |
| auto_dout | input | 4 | Data lanes from the automatic engine |
| link_cs_n | output | 1 | Chip select to the link |
| link_sck | output | 1 | Clock to the link |
| link_dout | output | 4 | Data lanes to the link |
| sync_idle | output | 1 | Nothing queued and the machine is idle |

## Verification
The bench attacks the edge where the buffer is taken by IDLE and refilled in the same cycle. A design that refused that refill would lose the second command of a burst. A design that accepted a third command would add 8 extra clock pulses. It checks lane order for the dual and quad modes, where a swapped lane index gives the wrong bit pairs on the pins. It also sends commands with the write flag clear, with an unlisted code, or with the manual enable off, and a design that let any of these through would show a chip-select change. Finally it moves the pin source to the automatic engine in the middle of a shift: a registered multiplexer would show one stale cycle, and a design whose shifting depended on the select would show a wrong pulse count afterwards.

// File: rtl/msq_pkg.sv
package msq_pkg;

    localparam int CMD_W   = 16;
    localparam int BYTE_W  = 8;
    localparam int LANES   = 4;
    localparam int WR_BIT  = 13;
    localparam int OP_LSB  = 8;

    typedef enum logic [3:0] {
        OP_CS_HI = 4'd0,
        OP_CS_LO = 4'd1,
        OP_PULSE = 4'd2,
        OP_OUT1  = 4'd8,
        OP_OUT2  = 4'd9,
        OP_OUT4  = 4'd10
    } op_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LOW,
        ST_HIGH
    } st_e;

    function automatic logic op_known(input logic [3:0] code);
        case (code)
            4'd0, 4'd1, 4'd2, 4'd8, 4'd9, 4'd10: op_known = 1'b1;
            default:                              op_known = 1'b0;
        endcase
    endfunction

    // Top bits of the shift register spread over the lanes for a given lane count.
    function automatic logic [LANES-1:0] lane_bits(input logic [BYTE_W-1:0] v,
                                                   input logic [2:0] w);
        case (w)
            3'd1:    lane_bits = {3'b000, v[BYTE_W-1]};
            3'd2:    lane_bits = {2'b00, v[BYTE_W-1 -: 2]};
            default: lane_bits = v[BYTE_W-1 -: 4];
        endcase
    endfunction

endpackage

// File: rtl/msq_cmd_buf.sv
module msq_cmd_buf
    import msq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [CMD_W-1:0]  wdata,
    input  logic              man_en,
    input  logic              take,
    output logic              accept,
    output logic              pend_v,
    output op_e               pend_op,
    output logic [BYTE_W-1:0] pend_byte
);

    logic unused_bits;
    assign unused_bits = ^{wdata[CMD_W-1:WR_BIT+1], wdata[WR_BIT-1:OP_LSB+4]};

    logic well_formed;
    assign well_formed = wdata[WR_BIT] && op_known(wdata[OP_LSB +: 4]);
    assign accept      = wr && man_en && well_formed && (!pend_v || take);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_v    <= 1'b0;
            pend_op   <= OP_CS_HI;
            pend_byte <= '0;
        end else begin
            if (accept) begin
                pend_v    <= 1'b1;
                pend_op   <= op_e'(wdata[OP_LSB +: 4]);
                pend_byte <= wdata[BYTE_W-1:0];
            end else if (take) begin
                pend_v    <= 1'b0;
            end
        end
    end

    // R8: a waiting command is kept intact until the sequencer takes it
    a_r8_hold_pending: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_v && !take) |=> (pend_v && $stable(pend_byte) && $stable(pend_op)));

endmodule

// File: rtl/msq_shifter.sv
module msq_shifter
    import msq_pkg::*;
#(
    parameter int HALF_CYC = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pend_v,
    input  op_e               pend_op,
    input  logic [BYTE_W-1:0] pend_byte,
    output logic              take,
    output logic              idle,
    output logic              cs_q,
    output logic              sck_q,
    output logic [LANES-1:0]  dq_q
);

    localparam int TMR_W  = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
    localparam int NCLK_W = $clog2(BYTE_W + 1);

    st_e               st, st_n;
    logic [TMR_W-1:0]  tmr;
    logic [NCLK_W-1:0] nclk;
    logic [BYTE_W-1:0] sr;
    logic [2:0]        lw;
    logic              tmr_done, last, clocked;

    assign tmr_done = (tmr == TMR_W'(HALF_CYC - 1));
    assign last     = (nclk == NCLK_W'(1));
    assign clocked  = (pend_op != OP_CS_HI) && (pend_op != OP_CS_LO);
    assign idle     = (st == ST_IDLE);

    always_comb begin
        st_n = st;
        take = 1'b0;
        unique case (st)
            ST_IDLE: if (pend_v) begin
                take = 1'b1;
                if (clocked) st_n = ST_LOW;
            end
            ST_LOW:  if (tmr_done) st_n = ST_HIGH;
            ST_HIGH: if (tmr_done) st_n = last ? ST_IDLE : ST_LOW;
            default: st_n = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_q  <= 1'b1;
            sck_q <= 1'b0;
            dq_q  <= '0;
            sr    <= '0;
            nclk  <= '0;
            lw    <= 3'd1;
            tmr   <= '0;
        end else begin
            tmr <= (st == ST_IDLE || tmr_done) ? '0 : tmr + 1'b1;
            unique case (st)
                ST_IDLE: if (pend_v) begin
                    case (pend_op)
                        OP_CS_HI: cs_q <= 1'b1;
                        OP_CS_LO: cs_q <= 1'b0;
                        OP_PULSE: nclk <= NCLK_W'(1);
                        OP_OUT1: begin
                            nclk <= NCLK_W'(BYTE_W);
                            lw   <= 3'd1;
                            dq_q <= lane_bits(pend_byte, 3'd1);
                            sr   <= pend_byte << 1;
                        end
                        OP_OUT2: begin
                            nclk <= NCLK_W'(BYTE_W / 2);
                            lw   <= 3'd2;
                            dq_q <= lane_bits(pend_byte, 3'd2);
                            sr   <= pend_byte << 2;
                        end
                        default: begin
                            nclk <= NCLK_W'(BYTE_W / 4);
                            lw   <= 3'd4;
                            dq_q <= lane_bits(pend_byte, 3'd4);
                            sr   <= pend_byte << 4;
                        end
                    endcase
                end
                ST_LOW: if (tmr_done) sck_q <= 1'b1;
                ST_HIGH: if (tmr_done) begin
                    sck_q <= 1'b0;
                    if (!last) begin
                        nclk <= nclk - 1'b1;
                        dq_q <= lane_bits(sr, lw);
                        sr   <= sr << lw;
                    end
                end
                default: ;
            endcase
        end
    end

    // R3: chip select moves only on a command taken in IDLE
    a_r3_cs_from_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cs_q) |-> ($past(st) == ST_IDLE));

    // R4: the clock rests low whenever the machine is idle
    a_r4_sck_low_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE) |-> !sck_q);

    // R5: lanes never change on the rising clock
    a_r5_data_on_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sck_q) |-> $stable(dq_q));

    // R4: while in HIGH the clock line is high
    a_r4_high_state: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_HIGH) |-> sck_q);

endmodule

// File: rtl/msq_pin_mux.sv
module msq_pin_mux
    import msq_pkg::*;
(
    input  logic             use_man,
    input  logic             m_cs,
    input  logic             m_sck,
    input  logic [LANES-1:0] m_dq,
    input  logic             a_cs,
    input  logic             a_sck,
    input  logic [LANES-1:0] a_dq,
    output logic             o_cs,
    output logic             o_sck,
    output logic [LANES-1:0] o_dq
);

    always_comb begin
        if (use_man) begin
            o_cs  = m_cs;
            o_sck = m_sck;
            o_dq  = m_dq;
        end else begin
            o_cs  = a_cs;
            o_sck = a_sck;
            o_dq  = a_dq;
        end
    end

endmodule

// File: rtl/manual_link_seq.sv
module manual_link_seq
    import msq_pkg::*;
#(
    parameter int HALF_CYC = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cmd_wr,
    input  logic [15:0] cmd_data,
    input  logic        man_en,
    input  logic        man_sel,
    input  logic        auto_cs_n,
    input  logic        auto_sck,
    input  logic [3:0]  auto_dout,
    output logic        link_cs_n,
    output logic        link_sck,
    output logic [3:0]  link_dout,
    output logic        sync_idle
);

    logic              accept, pend_v, take, sh_idle;
    op_e               pend_op;
    logic [BYTE_W-1:0] pend_byte;
    logic              m_cs, m_sck;
    logic [LANES-1:0]  m_dq;

    msq_cmd_buf u_buf (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr        (cmd_wr),
        .wdata     (cmd_data),
        .man_en    (man_en),
        .take      (take),
        .accept    (accept),
        .pend_v    (pend_v),
        .pend_op   (pend_op),
        .pend_byte (pend_byte)
    );

    msq_shifter #(.HALF_CYC(HALF_CYC)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .pend_v    (pend_v),
        .pend_op   (pend_op),
        .pend_byte (pend_byte),
        .take      (take),
        .idle      (sh_idle),
        .cs_q      (m_cs),
        .sck_q     (m_sck),
        .dq_q      (m_dq)
    );

    msq_pin_mux u_mux (
        .use_man (man_en && man_sel),
        .m_cs    (m_cs),
        .m_sck   (m_sck),
        .m_dq    (m_dq),
        .a_cs    (auto_cs_n),
        .a_sck   (auto_sck),
        .a_dq    (auto_dout),
        .o_cs    (link_cs_n),
        .o_sck   (link_sck),
        .o_dq    (link_dout)
    );

    assign sync_idle = sh_idle && !pend_v;

    // R9: a taken command makes the link busy in the next cycle
    a_r9_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> !sync_idle);

endmodule

// File: tb/test_manual_link_seq.sv
module test_manual_link_seq;

    localparam int H = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_wr = 1'b0;
    logic [15:0] cmd_data = '0;
    logic        man_en = 1'b1;
    logic        man_sel = 1'b1;
    logic        auto_cs_n = 1'b0;
    logic        auto_sck = 1'b1;
    logic [3:0]  auto_dout = 4'hA;
    logic        link_cs_n, link_sck, sync_idle;
    logic [3:0]  link_dout;

    int    n_checks = 0;
    int    n_errors = 0;
    bit    finished = 0;
    string cur_req = "R1";
    int    rises = 0;
    logic  prev_sck = 1'b0;

    always #4 clk = ~clk;

    manual_link_seq #(.HALF_CYC(H)) i_manual_link_seq (
        .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_data(cmd_data),
        .man_en(man_en), .man_sel(man_sel), .auto_cs_n(auto_cs_n),
        .auto_sck(auto_sck), .auto_dout(auto_dout), .link_cs_n(link_cs_n),
        .link_sck(link_sck), .link_dout(link_dout), .sync_idle(sync_idle)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
        end
    endtask

    // Reference model: frames {idle, cs, sck, dq[3:0]} for each coming cycle.
    logic [6:0]  script[$];
    logic [15:0] mpend[$];
    logic        m_cs = 1'b1, m_sck = 1'b0, m_idle = 1'b1;
    logic [3:0]  m_dq = 4'h0;

    function automatic logic [3:0] lanes_of(input logic [7:0] b, input int w, input int k);
        int v;
        v = (int'(b) << (k * w)) & 8'hFF;
        return 4'(v >> (8 - w));
    endfunction

    task automatic expand(input logic [15:0] c);
        int w, n;
        logic [3:0] d;
        int op;
        op = int'(c[11:8]);
        w = (op == 8) ? 1 : (op == 9) ? 2 : 4;
        n = (op == 2) ? 1 : 8 / w;
        d = m_dq;
        for (int k = 0; k < n; k++) begin
            if (op != 2) d = lanes_of(c[7:0], w, k);
            for (int i = 0; i < H; i++) script.push_back({1'b0, m_cs, 1'b0, d});
            for (int i = 0; i < H; i++) script.push_back({1'b0, m_cs, 1'b1, d});
        end
        script.push_back({1'b1, m_cs, 1'b0, d});
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            script.delete(); mpend.delete();
            m_cs = 1'b1; m_sck = 1'b0; m_idle = 1'b1; m_dq = 4'h0;
        end else begin
            logic [6:0]  f;
            logic [15:0] c;
            if (script.size() > 0) begin
                f = script.pop_front();
                {m_idle, m_cs, m_sck, m_dq} = f;
            end else if (mpend.size() > 0) begin
                c = mpend.pop_front();
                if (c[11:8] == 4'd0)      begin m_cs = 1'b1; m_idle = 1'b1; end
                else if (c[11:8] == 4'd1) begin m_cs = 1'b0; m_idle = 1'b1; end
                else begin
                    expand(c);
                    f = script.pop_front();
                    {m_idle, m_cs, m_sck, m_dq} = f;
                end
            end
            if (cmd_wr && man_en && cmd_data[13] && mpend.size() == 0 &&
                (cmd_data[11:8] inside {4'd0, 4'd1, 4'd2, 4'd8, 4'd9, 4'd10}))
                mpend.push_back(cmd_data);
        end
    end

    always @(posedge clk) begin
        #2;
        if (rst_n && !finished) begin
            logic use_man;
            use_man = man_en && man_sel;
            chk(cur_req, "cs",   32'(link_cs_n), 32'(use_man ? m_cs  : auto_cs_n));
            chk(cur_req, "sck",  32'(link_sck),  32'(use_man ? m_sck : auto_sck));
            chk(cur_req, "dout", 32'(link_dout), 32'(use_man ? m_dq  : auto_dout));
            chk("R9", "sync_idle", 32'(sync_idle),
                32'(m_idle && script.size() == 0 && mpend.size() == 0));
            if (link_sck && !prev_sck && use_man) rises++;
            prev_sck = link_sck;
        end
    end

    task automatic send(input logic [15:0] c);
        @(negedge clk);
        cmd_wr = 1'b1; cmd_data = c;
        @(negedge clk);
        cmd_wr = 1'b0; cmd_data = '0;
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (!sync_idle) @(negedge clk);
    endtask

    task automatic issue(input logic [15:0] c);
        wait_idle();
        send(c);
        wait_idle();
    endtask

    function automatic logic [15:0] mk(input int op, input logic [7:0] b);
        return {2'b00, 1'b1, 1'b0, 4'(op), b};
    endfunction

    task automatic finish_up();
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++; n_errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_up();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state visible at the pins
        chk("R1", "cs reset",   32'(link_cs_n), 32'd1);
        chk("R1", "sck reset",  32'(link_sck),  32'd0);
        chk("R1", "dout reset", 32'(link_dout), 32'd0);
        chk("R1", "idle reset", 32'(sync_idle), 32'd1);

        // R2: malformed or disabled commands have no effect
        cur_req = "R2";
        send(16'h0100);            // write flag clear, chip-select low code
        send(mk(5, 8'h00));        // unlisted code
        man_en = 1'b0;
        send(mk(1, 8'h00));        // manual path disabled
        @(negedge clk);
        man_en = 1'b1;
        @(negedge clk);
        chk("R2", "cs unchanged", 32'(link_cs_n), 32'd1);
        chk("R2", "still idle",   32'(sync_idle), 32'd1);

        // R3: chip select levels
        cur_req = "R3";
        issue(mk(1, 8'h00));
        chk("R3", "cs low", 32'(link_cs_n), 32'd0);

        // R4: single clock pulse
        cur_req = "R4"; rises = 0;
        issue(mk(2, 8'hFF));
        chk("R4", "one pulse", 32'(rises), 32'd1);

        // R5: single lane
        cur_req = "R5"; rises = 0;
        issue(mk(8, 8'hA5));
        chk("R5", "8 pulses", 32'(rises), 32'd8);
        chk("R5", "last bit", 32'(link_dout), 32'd1);

        // R6: dual lane
        cur_req = "R6"; rises = 0;
        issue(mk(9, 8'h6C));
        chk("R6", "4 pulses", 32'(rises), 32'd4);
        chk("R6", "last pair", 32'(link_dout), 32'h0);

        // R7: quad lane
        cur_req = "R7"; rises = 0;
        issue(mk(10, 8'h3E));
        chk("R7", "2 pulses", 32'(rises), 32'd2);
        chk("R7", "last nibble", 32'(link_dout), 32'hE);

        // R8: burst of three, the third is dropped
        cur_req = "R8"; rises = 0;
        wait_idle();
        @(negedge clk); cmd_wr = 1'b1; cmd_data = mk(8, 8'h81);
        @(negedge clk); cmd_data = mk(8, 8'h42);
        @(negedge clk); cmd_data = mk(8, 8'hFF);
        @(negedge clk); cmd_wr = 1'b0; cmd_data = '0;
        wait_idle();
        chk("R8", "two bytes only", 32'(rises), 32'd16);
        chk("R8", "second byte tail", 32'(link_dout), 32'd0);

        // R10: hand the pins to the automatic engine mid-shift
        cur_req = "R10"; rises = 0;
        send(mk(9, 8'hC3));
        @(negedge clk); man_sel = 1'b0; auto_dout = 4'h5;
        @(negedge clk);
        chk("R10", "auto cs",   32'(link_cs_n), 32'(auto_cs_n));
        chk("R10", "auto dout", 32'(link_dout), 32'h5);
        man_sel = 1'b1;
        wait_idle();
        chk("R10", "manual back", 32'(link_dout), 32'h3);

        // R11: slave reset series with idle polling
        cur_req = "R11"; rises = 0;
        issue(mk(1, 8'h00));
        issue(mk(8, 8'h00));
        issue(mk(0, 8'h00));
        for (int i = 0; i < 4; i++) issue(mk(8, 8'h00));
        chk("R11", "40 pulses", 32'(rises), 32'd40);
        chk("R11", "cs high",   32'(link_cs_n), 32'd1);

        repeat (4) @(negedge clk);
        finish_up();
    end

endmodule